// File: doc/BRIEF.md
# Multiplexed-Bus Nibble-Burst DRAM Controller

This block is a memory controller on a bus that carries address and data on one set of lines. A transaction begins with a start strobe. In that cycle the controller captures a word address and a read/write qualifier from the bus lines. It then runs a fixed burst of four words against nibble-mode DRAM. Four wait cycles cover the DRAM access time, which is about 160 ns at a 25 MHz clock. Four data cycles follow. On a read the controller drives the bus lines in those cycles. On a write the DRAM takes its data from them.

The DRAM side has a single 11-bit row/column address, a shared CAS and a shared write enable. Two banks, main memory and video memory, share that address. Each bank has its own RAS line. One bit of the captured address picks the bank, and only that bank's RAS falls during the burst. After the first access the later words come from nibble mode: CAS changes level once per data cycle while RAS stays low, and no new column is presented.

A one-cycle done pulse marks the last data word. A precharge cycle follows, with RAS and CAS high, before a new start is accepted. Refresh requests are taken only while the controller is idle. Each one runs a CAS-before-RAS cycle on both banks. A start in the same cycle wins over a refresh request.

Top module: `mbus_burst_dram`

## Requirements
- R1: When `start` is high in an idle cycle (cycle 0), the controller captures the address fields and `wr` from `bus_in` on that clock edge.
- R2: A burst occupies cycles 1 to 8. Cycles 1 to 4 are wait cycles and cycles 5 to 8 carry data words 0 to 3. `done` is high in cycle 8 only.
- R3: `dram_addr` carries the row `bus_in[21:11]` in cycle 1 and the column `bus_in[10:0]` in cycles 2 to 8, both taken from the captured address.
- R4: Captured bit 22 selects the bank: 0 selects main (`ras_main_n`) and 1 selects video (`ras_video_n`). Only the selected RAS is low, and it is low in cycles 1 to 8.
- R5: `cas_n` is high in cycles 1 to 3 and low in cycle 4. It then changes level at the start of every data cycle: high in cycles 5 and 7, low in cycles 6 and 8.
- R6: On a read (`wr`=0), `bus_oe` is high and `bus_out` equals `mem_rdata` in cycles 5 to 8 only. Otherwise `bus_oe` is low and `bus_out` is zero.
- R7: On a write (`wr`=1), `we_n` is low in cycles 1 to 8, and `mem_wdata` equals `bus_in` in cycles 5 to 8. At all other times `mem_wdata` is zero and `we_n` is high.
- R8: Cycle 9 is a precharge cycle with both RAS lines and `cas_n` high. A start in cycle 9 is ignored, and a new start is accepted from cycle 10.
- R9: A start that arrives during cycles 1 to 8 has no effect on the address, the bank, the direction or the timing of the running burst.
- R10: When `refresh_req` is high and `start` is low in an idle cycle, the controller runs a refresh. In refresh cycle 1, `cas_n` is low with both RAS lines high. In refresh cycles 2 and 3, `cas_n` and both RAS lines are low, and `refresh_ack` is high in cycle 3 only. Refresh cycle 4 precharges with everything high.
- R11: A start in an idle cycle takes priority over a pending refresh request. `done` never pulses during a refresh.
- R12: Under reset, both RAS lines, `cas_n` and `we_n` are high, and `done`, `refresh_ack` and `bus_oe` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a transaction in an idle cycle |
| wr | input | 1 | Direction qualifier sampled with start, 1 for write |
| bus_in | input | 32 | Shared bus lines as seen by the controller (address, then write data) |
| bus_out | output | 32 | Read data driven toward the shared bus |
| bus_oe | output | 1 | Output enable for bus_out |
| refresh_req | input | 1 | Refresh request, taken only while idle |
| refresh_ack | output | 1 | Pulses in the last RAS cycle of a refresh |
| done | output | 1 | Pulses in the last data cycle of a burst |
| dram_addr | output | 11 | Multiplexed row/column address shared by both banks |
| ras_main_n | output | 1 | Row strobe, main-memory bank |
| ras_video_n | output | 1 | Row strobe, video-memory bank |
| cas_n | output | 1 | Shared column strobe |
| we_n | output | 1 | Shared DRAM write enable |
| mem_wdata | output | 32 | Write data toward the DRAM |
| mem_rdata | input | 32 | Read data from the DRAM |

## Verification
The bench builds the block with its default parameters: a 32-bit bus, an 11-bit DRAM address, four wait cycles, four beats, one precharge cycle and two refresh RAS cycles. The captured field is then 23 bits wide. Random 32-bit bus words therefore reach both banks and the all-ones and all-zeros rows and columns. Every cycle of the nine-cycle window, and the parity of the CAS toggle across the data cycles, is compared against the numbered timeline. The same parameters put start strobes in every cycle of a burst, including the single precharge cycle.

// File: rtl/mbd_pkg.sv
// Package: shared types for the multiplexed-bus burst DRAM controller.
// Assumes: nothing beyond IEEE 1800-2017.
package mbd_pkg;
    // Sequencer phases. Bursts use ROW/WAIT/DATA, refresh uses RCAS/RRAS,
    // and both end in PRE.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_WAIT,
        ST_DATA,
        ST_PRE,
        ST_RCAS,
        ST_RRAS
    } seq_state_t;
endpackage

// File: rtl/mbd_addr_latch.sv
// Module: mbd_addr_latch
// Captures the word address and direction from the shared bus in the
// address cycle. It splits the address into row, column and bank select.
// Assumes: load is high for exactly the accepting idle cycle.
module mbd_addr_latch #(
    parameter int DA_W   = 11,
    localparam int ADDR_W = 2 * DA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [DA_W-1:0]   row_q,
    output logic [DA_W-1:0]   col_q,
    output logic              bank_q,
    output logic              wr_q
);
    // Register the address fields and direction when a burst is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            col_q  <= '0;
            bank_q <= 1'b0;
            wr_q   <= 1'b0;
        end else if (load) begin
            col_q  <= addr_in[DA_W-1:0];
            row_q  <= addr_in[2*DA_W-1:DA_W];
            bank_q <= addr_in[2*DA_W];
            wr_q   <= wr;
        end
    end
endmodule

// File: rtl/mbd_sequencer.sv
// Module: mbd_sequencer
// Phase sequencer. It moves through row, wait and data phases for a burst,
// or CAS and RAS phases for a refresh, and ends each in a precharge phase.
// A start is taken only in IDLE, where it beats a refresh request.
// Assumes: WAIT_CYC >= 2, BEATS >= 1, PRE_CYC >= 1, REF_RAS_CYC >= 1.
module mbd_sequencer
    import mbd_pkg::*;
#(
    parameter int WAIT_CYC    = 4,
    parameter int BEATS       = 4,
    parameter int PRE_CYC     = 1,
    parameter int REF_RAS_CYC = 2,
    localparam int CNT_W = $clog2(WAIT_CYC + BEATS + PRE_CYC + REF_RAS_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             refresh_req,
    output seq_state_t       state,
    output logic [CNT_W-1:0] cnt,
    output logic             accept
);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 2);
    localparam logic [CNT_W-1:0] BEAT_LAST = CNT_W'(BEATS - 1);
    localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_CYC - 1);
    localparam logic [CNT_W-1:0] RRAS_LAST = CNT_W'(REF_RAS_CYC - 1);

    // A start is accepted only when idle.
    assign accept = (state == ST_IDLE) && start;

    // Advance the phase and its in-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start)            state <= ST_ROW;
                    else if (refresh_req) state <= ST_RCAS;
                end
                ST_ROW: begin
                    cnt   <= '0;
                    state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (cnt == WAIT_LAST) begin
                        cnt   <= '0;
                        state <= ST_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt == BEAT_LAST) begin
                        cnt   <= '0;
                        state <= ST_PRE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PRE: begin
                    if (cnt == PRE_LAST) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RCAS: begin
                    cnt   <= '0;
                    state <= ST_RRAS;
                end
                ST_RRAS: begin
                    if (cnt == RRAS_LAST) begin
                        cnt   <= '0;
                        state <= ST_PRE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    cnt   <= '0;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // R9: a row phase is entered only from idle, never from within a burst.
    p_row_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROW) |-> ($past(state) == ST_IDLE));

    // R2: the data phase always follows the wait phase.
    p_data_after_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DATA) && ($past(state) != ST_DATA)) |-> ($past(state) == ST_WAIT));
endmodule

// File: rtl/mbd_pin_decode.sv
// Module: mbd_pin_decode
// Decodes the sequencer phase into the DRAM strobes and the multiplexed
// address, and the done and refresh-acknowledge pulses.
// Assumes: the outputs are Moore decodes of registered phase state.
module mbd_pin_decode
    import mbd_pkg::*;
#(
    parameter int DA_W        = 11,
    parameter int WAIT_CYC    = 4,
    parameter int BEATS       = 4,
    parameter int REF_RAS_CYC = 2,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_t       state,
    input  logic [CNT_W-1:0] cnt,
    input  logic [DA_W-1:0]  row_q,
    input  logic [DA_W-1:0]  col_q,
    input  logic             bank_q,
    input  logic             wr_q,
    output logic [DA_W-1:0]  dram_addr,
    output logic             ras_main_n,
    output logic             ras_video_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             done,
    output logic             refresh_ack
);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 2);
    localparam logic [CNT_W-1:0] BEAT_LAST = CNT_W'(BEATS - 1);
    localparam logic [CNT_W-1:0] RRAS_LAST = CNT_W'(REF_RAS_CYC - 1);

    logic in_burst;
    logic in_ref_ras;

    // Phase classification shared by the strobe decodes.
    always_comb begin
        in_burst   = (state == ST_ROW) || (state == ST_WAIT) || (state == ST_DATA);
        in_ref_ras = (state == ST_RRAS);
    end

    // Row strobes: the selected bank during a burst, both banks in refresh.
    always_comb begin
        ras_main_n  = !((in_burst && !bank_q) || in_ref_ras);
        ras_video_n = !((in_burst &&  bank_q) || in_ref_ras);
    end

    // Column strobe: first fall in the last wait cycle, then one level change per beat.
    always_comb begin
        case (state)
            ST_WAIT: cas_n = (cnt != WAIT_LAST);
            ST_DATA: cas_n = !cnt[0];
            ST_RCAS: cas_n = 1'b0;
            ST_RRAS: cas_n = 1'b0;
            default: cas_n = 1'b1;
        endcase
    end

    // Write enable held for the whole write burst; address is row first, then column.
    always_comb begin
        we_n      = !(in_burst && wr_q);
        dram_addr = (state == ST_ROW) ? row_q : col_q;
    end

    // One-cycle completion pulses.
    always_comb begin
        done        = (state == ST_DATA) && (cnt == BEAT_LAST);
        refresh_ack = in_ref_ras && (cnt == RRAS_LAST);
    end

    // R10: both banks share a RAS low only in refresh, with CAS already low.
    p_cbr_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_main_n && !ras_video_n) |-> (!cas_n && $past(!cas_n)));

    // R8: the cycle after done is a precharge cycle.
    p_precharge_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ras_main_n && ras_video_n && cas_n));

    // R2: done is a single-cycle pulse.
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/mbd_data_path.sv
// Module: mbd_data_path
// Steers data between the shared bus and the DRAM data lines in the four
// data cycles. Reads drive the bus, and writes pass the bus to the DRAM.
// Assumes: the DRAM read data is valid within each data cycle.
module mbd_data_path
    import mbd_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  seq_state_t       state,
    input  logic             wr_q,
    input  logic [BUS_W-1:0] bus_in,
    input  logic [BUS_W-1:0] mem_rdata,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    output logic [BUS_W-1:0] mem_wdata
);
    logic data_phase;

    // Gate both directions to the data phase only.
    always_comb begin
        data_phase = (state == ST_DATA);
        bus_oe     = data_phase && !wr_q;
        bus_out    = bus_oe ? mem_rdata : '0;
        mem_wdata  = (data_phase && wr_q) ? bus_in : '0;
    end
endmodule

// File: rtl/mbus_burst_dram.sv
// Module: mbus_burst_dram (top)
// Burst DRAM controller for a multiplexed address/data bus. It captures the
// address in the start cycle, runs a fixed four-beat nibble burst on one of
// two banks that share the address lines, and services refresh while idle.
// Assumes: BUS_W >= 2*DA_W+1. The bus master waits for done.
module mbus_burst_dram
    import mbd_pkg::*;
#(
    parameter int BUS_W       = 32,
    parameter int DA_W        = 11,
    parameter int WAIT_CYC    = 4,
    parameter int BEATS       = 4,
    parameter int PRE_CYC     = 1,
    parameter int REF_RAS_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wr,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    input  logic             refresh_req,
    output logic             refresh_ack,
    output logic             done,
    output logic [DA_W-1:0]  dram_addr,
    output logic             ras_main_n,
    output logic             ras_video_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [BUS_W-1:0] mem_wdata,
    input  logic [BUS_W-1:0] mem_rdata
);
    localparam int ADDR_W = 2 * DA_W + 1;
    localparam int CNT_W  = $clog2(WAIT_CYC + BEATS + PRE_CYC + REF_RAS_CYC + 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             accept;
    logic [DA_W-1:0]  row_q;
    logic [DA_W-1:0]  col_q;
    logic             bank_q;
    logic             wr_q;

    mbd_sequencer #(
        .WAIT_CYC(WAIT_CYC), .BEATS(BEATS),
        .PRE_CYC(PRE_CYC), .REF_RAS_CYC(REF_RAS_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .refresh_req(refresh_req),
        .state(state), .cnt(cnt), .accept(accept)
    );

    mbd_addr_latch #(.DA_W(DA_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(accept), .wr(wr),
        .addr_in(bus_in[ADDR_W-1:0]),
        .row_q(row_q), .col_q(col_q), .bank_q(bank_q), .wr_q(wr_q)
    );

    mbd_pin_decode #(
        .DA_W(DA_W), .WAIT_CYC(WAIT_CYC), .BEATS(BEATS),
        .REF_RAS_CYC(REF_RAS_CYC), .CNT_W(CNT_W)
    ) u_pins (
        .clk(clk), .rst_n(rst_n), .state(state), .cnt(cnt),
        .row_q(row_q), .col_q(col_q), .bank_q(bank_q), .wr_q(wr_q),
        .dram_addr(dram_addr), .ras_main_n(ras_main_n), .ras_video_n(ras_video_n),
        .cas_n(cas_n), .we_n(we_n), .done(done), .refresh_ack(refresh_ack)
    );

    mbd_data_path #(.BUS_W(BUS_W)) u_data (
        .state(state), .wr_q(wr_q), .bus_in(bus_in), .mem_rdata(mem_rdata),
        .bus_out(bus_out), .bus_oe(bus_oe), .mem_wdata(mem_wdata)
    );

    // R9: the captured transfer fields hold still while a transaction runs.
    p_fields_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable({row_q, col_q, bank_q, wr_q}));

    // R6: the bus is driven only on reads, with exactly one bank open.
    p_oe_read_one_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (we_n && (ras_main_n != ras_video_n)));

    // R11: done is never raised while a refresh holds both banks.
    p_no_done_in_refresh_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_main_n && !ras_video_n) |-> !done);
endmodule

// File: tb/sim_mbus_burst_dram.sv
// Bench for mbus_burst_dram. It mixes directed corner cases with seeded
// random bursts and checks every cycle against a numbered timeline model.
module sim_mbus_burst_dram;
    localparam int BUS_W = 32;
    localparam int DA_W  = 11;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start;
    logic             wr;
    logic [BUS_W-1:0] bus_in;
    logic [BUS_W-1:0] bus_out;
    logic             bus_oe;
    logic             refresh_req;
    logic             refresh_ack;
    logic             done;
    logic [DA_W-1:0]  dram_addr;
    logic             ras_main_n;
    logic             ras_video_n;
    logic             cas_n;
    logic             we_n;
    logic [BUS_W-1:0] mem_wdata;
    logic [BUS_W-1:0] mem_rdata;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    mbus_burst_dram u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .refresh_req(refresh_req),
        .refresh_ack(refresh_ack), .done(done), .dram_addr(dram_addr),
        .ras_main_n(ras_main_n), .ras_video_n(ras_video_n), .cas_n(cas_n),
        .we_n(we_n), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected {ras_video_n, ras_main_n} in burst cycle k.
    function automatic logic [1:0] exp_ras(input logic bank, input int k);
        if (k >= 1 && k <= 8) return bank ? 2'b01 : 2'b10;
        return 2'b11;
    endfunction

    // Expected cas_n in burst cycle k.
    function automatic logic exp_cas(input int k);
        if (k == 4) return 1'b0;
        if (k >= 5 && k <= 8) return (k % 2 == 1);
        return 1'b1;
    endfunction

    // Run one burst. A start carrying intr_addr is injected in cycle intr_k (0 = none).
    task automatic burst(input logic [31:0] a, input logic w, input int intr_k,
                         input logic [31:0] intr_addr, input logic ref_hold);
        logic bank;
        logic [DA_W-1:0] row;
        logic [DA_W-1:0] col;
        bank = a[2*DA_W];
        row  = a[2*DA_W-1:DA_W];
        col  = a[DA_W-1:0];
        @(negedge clk);
        start = 1'b1; wr = w; bus_in = a; refresh_req = ref_hold;
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            start     = 1'b0;
            wr        = $urandom_range(0, 1);
            bus_in    = $urandom;
            mem_rdata = $urandom;
            if (k == intr_k) begin
                start  = 1'b1;
                bus_in = intr_addr;
                wr     = ~w;
            end
            #1;
            chk("R4", "ras", {30'd0, ras_video_n, ras_main_n}, {30'd0, exp_ras(bank, k)});
            chk("R5", "cas_n", {31'd0, cas_n}, {31'd0, exp_cas(k)});
            chk("R7", "we_n", {31'd0, we_n}, {31'd0, (k <= 8) ? ~w : 1'b1});
            chk("R2", "done", {31'd0, done}, {31'd0, (k == 8)});
            if (k == 1) chk("R3", "row", {21'd0, dram_addr}, {21'd0, row});
            else if (k <= 8) chk("R3", "col", {21'd0, dram_addr}, {21'd0, col});
            chk("R6", "bus_oe", {31'd0, bus_oe}, {31'd0, (!w && k >= 5 && k <= 8)});
            chk("R6", "bus_out", bus_out, (!w && k >= 5 && k <= 8) ? mem_rdata : 32'd0);
            chk("R7", "mem_wdata", mem_wdata, (w && k >= 5 && k <= 8) ? bus_in : 32'd0);
            if (k == 9) chk("R8", "precharge ras", {30'd0, ras_video_n, ras_main_n}, 32'd3);
        end
        if (intr_k == 9) begin
            @(negedge clk);
            start = 1'b0;
            #1;
            chk("R8", "start in precharge ignored", {30'd0, ras_video_n, ras_main_n}, 32'd3);
        end
    endtask

    // Run a refresh from idle and check its four cycles.
    task automatic refresh_seq();
        @(negedge clk);
        refresh_req = 1'b1; start = 1'b0;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            refresh_req = 1'b0;
            #1;
            chk("R10", "ref ras", {30'd0, ras_video_n, ras_main_n},
                (k == 2 || k == 3) ? 32'd0 : 32'd3);
            chk("R10", "ref cas", {31'd0, cas_n}, {31'd0, (k >= 4)});
            chk("R10", "ref ack", {31'd0, refresh_ack}, {31'd0, (k == 3)});
            chk("R11", "no done in refresh", {31'd0, done}, 32'd0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h0b0e_5eed));
        rst_n = 1'b0; start = 1'b0; wr = 1'b0; bus_in = '0;
        refresh_req = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R12", "reset ras", {30'd0, ras_video_n, ras_main_n}, 32'd3);
        chk("R12", "reset cas/we", {30'd0, cas_n, we_n}, 32'd3);
        chk("R12", "reset pulses", {29'd0, done, refresh_ack, bus_oe}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 directed: read to main bank, write to video bank, extreme fields.
        burst(32'h0012_3456, 1'b0, 0, 32'd0, 1'b0);
        burst(32'h0040_0000, 1'b1, 0, 32'd0, 1'b0);
        burst(32'hFFFF_FFFF, 1'b0, 0, 32'd0, 1'b0);
        burst(32'h003F_FFFF, 1'b1, 0, 32'd0, 1'b0);
        // R9: a start during wait and data cycles is ignored.
        burst(32'h0001_0801, 1'b0, 3, 32'h007F_FFFF, 1'b0);
        burst(32'h0055_5AAA, 1'b1, 6, 32'h0000_0000, 1'b0);
        // R8: a start in the precharge cycle is ignored.
        burst(32'h0022_2222, 1'b0, 9, 32'h0044_4444, 1'b0);
        // R10: refresh alone.
        refresh_seq();
        // R11: start beats a pending refresh, which then runs afterwards.
        burst(32'h0066_0F0F, 1'b0, 0, 32'd0, 1'b1);
        refresh_seq();

        // Random bursts with random injected starts.
        for (int i = 0; i < 60; i++) begin
            burst($urandom, $urandom_range(0, 1), $urandom_range(0, 9), $urandom, 1'b0);
            if ($urandom_range(0, 3) == 0) refresh_seq();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule